// File: doc/BRIEF.md
# SPI Controller Register and Interrupt Front-End

This block is the host-facing register layer of an SPI command engine. A simple 32-bit bus performs word reads and writes at byte addresses. Some addresses are ordinary registers:

- a version word;
- a soft-reset control that holds the engine and its FIFOs in reset;
- interrupt enable, pending and source registers;
- the identifier of the last completed synchronisation command;
- free-space and fill counts for the three FIFOs.

Other addresses are windows onto the FIFOs. A write to the command window or to the transmit window becomes a single-cycle push strobe. A read of the receive window pops the receive FIFO. A read of the peek window returns the head entry without removing it.

Four interrupt causes feed the pending register:

- the command FIFO is almost empty;
- the transmit FIFO is almost empty;
- the receive FIFO is almost full;
- a synchronisation command has completed.

Pending bits are sticky and are cleared by writing ones. A single interrupt line is raised while any enabled pending bit is set. The FIFOs, the serial shifter and any bus protocol wrapper sit outside this block. The FIFOs are expected to present their head entry on the same cycle (first-word fall-through), and to report their room or level as counts.

Top module: `spi_regfront`

## Requirements
- R1: A read of address 0x00 returns the version word. The major number sits in bits 23:16 and reads 1, the minor number sits in bits 15:8 (parameter, default 0), and the patch number sits in bits 7:0 (parameter, default 0x61). Every read's data and `busRdValid` appear one cycle after `busRdEn`.
- R2: The soft-reset register at 0x40 resets to 1 and drives `engineRst` from its bit 0. Writing 0 releases the engine, writing 1 holds it, and a read returns the stored bit.
- R3: The interrupt enable register at 0x80 holds 4 bits, resets to 0 and reads back what was written. Bits 31:4 read as 0.
- R4: The pending register at 0x84 has these bits: bit 0 for command almost empty, bit 1 for transmit almost empty, bit 2 for receive almost full and bit 3 for sync. A bit is set on any cycle its cause is present and stays set until a 1 is written to it. A cause present in the same cycle as a clear wins.
- R5: The source register at 0x88 returns the live, unmasked causes, with the same bit order as R4:
  - command almost empty when DEPTH minus `cmdRoom` is at most AE_LVL (default 4 of 16);
  - transmit almost empty by the same rule applied to `txRoom`;
  - receive almost full when `rxLevel` is at least AF_LVL (default 12);
  - sync equal to `syncDone`.
- R6: `irq` is high exactly while some bit is set in both the pending and the enable registers. It rises in the cycle after the register update that makes this true.
- R7: On a cycle with `syncDone` high, `syncId` is stored. A read of 0xC0 returns the stored 8-bit value.
- R8: Reads of 0xD0, 0xD4 and 0xD8 return `cmdRoom`, `txRoom` and `rxLevel`, zero-extended.
- R9: A write to 0xE0 pulses `cmdPush` in the same cycle, with `cmdData` equal to the write data. A write to 0xE4 pulses `txPush`, with `txData` equal to write data bits 7:0. No other write pulses either strobe.
- R10: A read of 0xE8 with `rxLevel` nonzero pulses `rxPop` in the request cycle and returns `rxHead`. With `rxLevel` zero it returns 0 and does not pop.
- R11: A read of 0xEC returns `rxHead`, or 0 when `rxLevel` is zero, and never pulses `rxPop`.
- R12: Reads of unmapped or unaligned addresses return 0. Writes to read-only addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write request, one cycle per word |
| busRdEn | input | 1 | Read request, one cycle per word |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| irq | output | 1 | Combined masked interrupt |
| engineRst | output | 1 | Holds engine and FIFOs in reset |
| cmdRoom | input | 5 | Free entries in command FIFO |
| txRoom | input | 5 | Free entries in transmit FIFO |
| rxLevel | input | 5 | Filled entries in receive FIFO |
| rxHead | input | 8 | Head entry of receive FIFO |
| syncDone | input | 1 | Sync command completed this cycle |
| syncId | input | 8 | Identifier of the completing sync command |
| cmdPush | output | 1 | Push strobe for command FIFO |
| cmdData | output | 32 | Command word to push |
| txPush | output | 1 | Push strobe for transmit FIFO |
| txData | output | 8 | Transmit byte to push |
| rxPop | output | 1 | Pop strobe for receive FIFO |

## Verification
The push and pop strobes are combinational from the request and are due in the request cycle itself. The bench samples them 1 ns after driving the request on a falling edge. Register writes take effect at the next rising edge, and read data is due one edge after the request. Each read task therefore raises `busRdEn` at one falling edge and samples `busRdata` and `busRdValid` at the following falling edge. Interrupt and pending effects are checked only after the edge that registers them, so every check falls half a cycle after the edge that produced its value.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

  localparam logic [7:0] ADDR_VER   = 8'h00;
  localparam logic [7:0] ADDR_RST   = 8'h40;
  localparam logic [7:0] ADDR_IEN   = 8'h80;
  localparam logic [7:0] ADDR_IPEND = 8'h84;
  localparam logic [7:0] ADDR_ISRC  = 8'h88;
  localparam logic [7:0] ADDR_SYNC  = 8'hC0;
  localparam logic [7:0] ADDR_CROOM = 8'hD0;
  localparam logic [7:0] ADDR_TROOM = 8'hD4;
  localparam logic [7:0] ADDR_RLVL  = 8'hD8;
  localparam logic [7:0] ADDR_CMD   = 8'hE0;
  localparam logic [7:0] ADDR_TX    = 8'hE4;
  localparam logic [7:0] ADDR_RXPOP = 8'hE8;
  localparam logic [7:0] ADDR_RXPK  = 8'hEC;

  localparam int NUM_CAUSE = 4;
  localparam int CAUSE_CMD = 0;
  localparam int CAUSE_TX  = 1;
  localparam int CAUSE_RX  = 2;
  localparam int CAUSE_SYN = 3;

  typedef enum logic [3:0] {
    RD_NONE, RD_VER, RD_RST, RD_IEN, RD_IPEND, RD_ISRC, RD_SYNC,
    RD_CROOM, RD_TROOM, RD_RLVL, RD_RXPOP, RD_RXPK
  } rdSel_e;

  typedef struct packed {
    logic   wrRst;
    logic   wrIen;
    logic   wrAck;
    logic   pushCmd;
    logic   pushTx;
    logic   popRx;
    logic   rdReq;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/spi_regfront_ctrl.sv
module spi_regfront_ctrl
  import spi_regfront_pkg::*;
(
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busAddr,
  input  logic       rxEmpty,
  output strobe_t    strb
);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    strb.rdReq = busRdEn;
    if (busWrEn) begin
      unique case (busAddr)
        ADDR_RST:   strb.wrRst   = 1'b1;
        ADDR_IEN:   strb.wrIen   = 1'b1;
        ADDR_IPEND: strb.wrAck   = 1'b1;
        ADDR_CMD:   strb.pushCmd = 1'b1;
        ADDR_TX:    strb.pushTx  = 1'b1;
        default: ;
      endcase
    end
    if (busRdEn) begin
      unique case (busAddr)
        ADDR_VER:   strb.rdSel = RD_VER;
        ADDR_RST:   strb.rdSel = RD_RST;
        ADDR_IEN:   strb.rdSel = RD_IEN;
        ADDR_IPEND: strb.rdSel = RD_IPEND;
        ADDR_ISRC:  strb.rdSel = RD_ISRC;
        ADDR_SYNC:  strb.rdSel = RD_SYNC;
        ADDR_CROOM: strb.rdSel = RD_CROOM;
        ADDR_TROOM: strb.rdSel = RD_TROOM;
        ADDR_RLVL:  strb.rdSel = RD_RLVL;
        ADDR_RXPOP: begin
          strb.rdSel = RD_RXPOP;
          strb.popRx = !rxEmpty;
        end
        ADDR_RXPK:  strb.rdSel = RD_RXPK;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_regfront_dp.sv
module spi_regfront_dp
  import spi_regfront_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int AE_LVL    = DEPTH / 4,
  parameter int AF_LVL    = (3 * DEPTH) / 4,
  parameter int DATA_W    = 8,
  parameter int SYNC_W    = 8,
  parameter int BUS_W     = 32,
  parameter int VER_MINOR = 0,
  parameter int VER_PATCH = 8'h61,
  localparam int LVL_W    = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [NUM_CAUSE-1:0] wrBits,
  input  logic [LVL_W-1:0]  cmdRoom,
  input  logic [LVL_W-1:0]  txRoom,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [DATA_W-1:0] rxHead,
  input  logic              syncDone,
  input  logic [SYNC_W-1:0] syncId,
  output logic [BUS_W-1:0]  busRdata,
  output logic              busRdValid,
  output logic              irq,
  output logic              engineRst
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] AE_L    = LVL_W'(AE_LVL);
  localparam logic [LVL_W-1:0] AF_L    = LVL_W'(AF_LVL);
  localparam logic [BUS_W-1:0] VER_WORD =
    BUS_W'({8'h00, 8'd1, 8'(VER_MINOR), 8'(VER_PATCH)});

  logic                 resetQ;
  logic [NUM_CAUSE-1:0] enableQ, pendingQ, cause;
  logic [SYNC_W-1:0]    syncIdQ;
  logic [LVL_W-1:0]     roomIn [2];
  logic [BUS_W-1:0]     rdNext;
  logic [BUS_W-1:0]     headOrZero;

  assign roomIn[0] = cmdRoom;
  assign roomIn[1] = txRoom;

  for (genvar g = 0; g < 2; g++) begin : g_almostEmpty
    assign cause[g] = (DEPTH_L - roomIn[g]) <= AE_L;
  end
  assign cause[CAUSE_RX]  = rxLevel >= AF_L;
  assign cause[CAUSE_SYN] = syncDone;

  assign headOrZero = (rxLevel != '0) ? BUS_W'(rxHead) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetQ   <= 1'b1;
      enableQ  <= '0;
      pendingQ <= '0;
      syncIdQ  <= '0;
    end else begin
      if (strb.wrRst) resetQ  <= wrBits[0];
      if (strb.wrIen) enableQ <= wrBits;
      pendingQ <= (pendingQ & ~(strb.wrAck ? wrBits : '0)) | cause;
      if (syncDone) syncIdQ <= syncId;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_VER:   rdNext = VER_WORD;
      RD_RST:   rdNext = BUS_W'(resetQ);
      RD_IEN:   rdNext = BUS_W'(enableQ);
      RD_IPEND: rdNext = BUS_W'(pendingQ);
      RD_ISRC:  rdNext = BUS_W'(cause);
      RD_SYNC:  rdNext = BUS_W'(syncIdQ);
      RD_CROOM: rdNext = BUS_W'(cmdRoom);
      RD_TROOM: rdNext = BUS_W'(txRoom);
      RD_RLVL:  rdNext = BUS_W'(rxLevel);
      RD_RXPOP, RD_RXPK: rdNext = headOrZero;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata   <= '0;
      busRdValid <= 1'b0;
    end else begin
      busRdValid <= strb.rdReq;
      busRdata   <= strb.rdReq ? rdNext : '0;
    end
  end

  assign irq       = |(pendingQ & enableQ);
  assign engineRst = resetQ;

  // R1: read data is always returned on the following cycle
  a_r1_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdReq |=> busRdValid);

  // R4: a completing sync always leaves its pending bit set
  a_r4_sync_sets: assert property (@(posedge clk) disable iff (!rstN)
    syncDone |=> pendingQ[CAUSE_SYN]);

  // R4: an acknowledge with no cause present clears the bit
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrAck && wrBits[CAUSE_CMD] && !cause[CAUSE_CMD]) |=> !pendingQ[CAUSE_CMD]);

  // R7: the stored sync identifier follows the completing command
  a_r7_id_capture: assert property (@(posedge clk) disable iff (!rstN)
    syncDone |=> (syncIdQ == $past(syncId)));

  // R10: the decoder never pops an empty receive FIFO
  a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strb.popRx |-> (rxLevel != '0));

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int AE_LVL    = DEPTH / 4,
  parameter int AF_LVL    = (3 * DEPTH) / 4,
  parameter int DATA_W    = 8,
  parameter int SYNC_W    = 8,
  parameter int BUS_W     = 32,
  parameter int VER_MINOR = 0,
  parameter int VER_PATCH = 8'h61,
  localparam int LVL_W    = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              busRdValid,
  output logic              irq,
  output logic              engineRst,
  input  logic [LVL_W-1:0]  cmdRoom,
  input  logic [LVL_W-1:0]  txRoom,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [DATA_W-1:0] rxHead,
  input  logic              syncDone,
  input  logic [SYNC_W-1:0] syncId,
  output logic              cmdPush,
  output logic [BUS_W-1:0]  cmdData,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  output logic              rxPop
);

  strobe_t strb;

  spi_regfront_ctrl u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .rxEmpty (rxLevel == '0),
    .strb    (strb)
  );

  spi_regfront_dp #(
    .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL), .DATA_W(DATA_W),
    .SYNC_W(SYNC_W), .BUS_W(BUS_W), .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrBits     (busWdata[NUM_CAUSE-1:0]),
    .cmdRoom    (cmdRoom),
    .txRoom     (txRoom),
    .rxLevel    (rxLevel),
    .rxHead     (rxHead),
    .syncDone   (syncDone),
    .syncId     (syncId),
    .busRdata   (busRdata),
    .busRdValid (busRdValid),
    .irq        (irq),
    .engineRst  (engineRst)
  );

  assign cmdPush = strb.pushCmd;
  assign cmdData = busWdata;
  assign txPush  = strb.pushTx;
  assign txData  = busWdata[DATA_W-1:0];
  assign rxPop   = strb.popRx;

endmodule

// File: tb/spi_regfront_bench.sv
module spi_regfront_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRdValid, irq, engineRst;
  logic [4:0]  cmdRoom = 5'd8, txRoom = 5'd8, rxLevel = 5'd0;
  logic [7:0]  rxHead = '0;
  logic        syncDone = 1'b0;
  logic [7:0]  syncId = '0;
  logic        cmdPush, txPush, rxPop;
  logic [31:0] cmdData;
  logic [7:0]  txData;

  int checks = 0;
  int errors = 0;
  logic        sawCmd, sawTx, sawPop, rdv;
  logic [31:0] cmdSeen, rd;
  logic [7:0]  txSeen;

  always #10 clk = ~clk;

  spi_regfront u_spi_regfront (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRdValid(busRdValid), .irq(irq), .engineRst(engineRst),
    .cmdRoom(cmdRoom), .txRoom(txRoom), .rxLevel(rxLevel), .rxHead(rxHead),
    .syncDone(syncDone), .syncId(syncId), .cmdPush(cmdPush), .cmdData(cmdData),
    .txPush(txPush), .txData(txData), .rxPop(rxPop)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    #1;
    sawCmd = cmdPush; cmdSeen = cmdData; sawTx = txPush; txSeen = txData;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1;
    sawPop = rxPop;
    @(negedge clk);
    busRdEn = 1'b0;
    rd = busRdata; rdv = busRdValid;
  endtask

  task automatic testReset();
    checkEq("R2 engineRst after reset", 32'(engineRst), 32'd1);
    checkEq("R6 irq after reset", 32'(irq), 32'd0);
    busRead(8'h84); checkEq("R4 pending after reset", rd, 32'h0);
    busRead(8'h80); checkEq("R3 enable after reset", rd, 32'h0);
  endtask

  task automatic testVersion();
    busRead(8'h00);
    checkEq("R1 version word", rd, 32'h0001_0061);
    checkEq("R1 read valid", 32'(rdv), 32'd1);
    @(negedge clk);
    checkEq("R1 valid drops", 32'(busRdValid), 32'd0);
  endtask

  task automatic testSoftReset();
    busWrite(8'h40, 32'h0);
    checkEq("R2 release", 32'(engineRst), 32'd0);
    busRead(8'h40); checkEq("R2 readback 0", rd, 32'h0);
    busWrite(8'h40, 32'h1);
    checkEq("R2 hold", 32'(engineRst), 32'd1);
    busWrite(8'h40, 32'h0);
  endtask

  task automatic testEnable();
    busWrite(8'h80, 32'hFFFF_FFFF);
    busRead(8'h80); checkEq("R3 enable width", rd, 32'hF);
    busWrite(8'h80, 32'h0);
    busRead(8'h80); checkEq("R3 enable cleared", rd, 32'h0);
  endtask

  task automatic testCauses();
    cmdRoom = 5'd11; txRoom = 5'd11; rxLevel = 5'd11;
    busRead(8'h88); checkEq("R5 below thresholds", rd, 32'h0);
    cmdRoom = 5'd12;
    busRead(8'h88); checkEq("R5 cmd almost empty", rd, 32'h1);
    cmdRoom = 5'd8; txRoom = 5'd12;
    busRead(8'h88); checkEq("R5 tx almost empty", rd, 32'h2);
    txRoom = 5'd8; rxLevel = 5'd12;
    busRead(8'h88); checkEq("R5 rx almost full", rd, 32'h4);
    rxLevel = 5'd0;
    busRead(8'h84); checkEq("R4 sticky pending", rd, 32'h7);
    busWrite(8'h84, 32'h1);
    busRead(8'h84); checkEq("R4 clear bit0 only", rd, 32'h6);
    busWrite(8'h84, 32'hFF);
    busRead(8'h84); checkEq("R4 clear all", rd, 32'h0);
  endtask

  task automatic testIrq();
    cmdRoom = 5'd16;
    @(negedge clk); cmdRoom = 5'd8;
    checkEq("R6 masked pending", 32'(irq), 32'd0);
    busWrite(8'h80, 32'h2);
    checkEq("R6 other enable", 32'(irq), 32'd0);
    busWrite(8'h80, 32'h1);
    checkEq("R6 irq raised", 32'(irq), 32'd1);
    busWrite(8'h84, 32'h1);
    checkEq("R6 irq dropped on ack", 32'(irq), 32'd0);
    busWrite(8'h80, 32'h0);
  endtask

  task automatic testSync();
    @(negedge clk); syncDone = 1'b1; syncId = 8'h5A;
    @(negedge clk); syncDone = 1'b0; syncId = 8'h00;
    busRead(8'hC0); checkEq("R7 sync id", rd, 32'h5A);
    busRead(8'h84); checkEq("R4 sync pending", rd, 32'h8);
    busRead(8'h88); checkEq("R5 sync source is live", rd, 32'h0);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 8'h84; busWdata = 32'h8; syncDone = 1'b1; syncId = 8'hA5;
    @(negedge clk);
    busWrEn = 1'b0; syncDone = 1'b0;
    busRead(8'h84); checkEq("R4 set beats clear", rd, 32'h8);
    busRead(8'hC0); checkEq("R7 sync id update", rd, 32'hA5);
    busWrite(8'h84, 32'h8);
    busRead(8'h84); checkEq("R4 sync cleared", rd, 32'h0);
  endtask

  task automatic testLevels();
    cmdRoom = 5'd7; txRoom = 5'd3; rxLevel = 5'd5;
    busRead(8'hD0); checkEq("R8 cmd room", rd, 32'd7);
    busRead(8'hD4); checkEq("R8 tx room", rd, 32'd3);
    busRead(8'hD8); checkEq("R8 rx level", rd, 32'd5);
    cmdRoom = 5'd8; txRoom = 5'd8; rxLevel = 5'd0;
  endtask

  task automatic testPush();
    busWrite(8'hE0, 32'hABCD_1234);
    checkEq("R9 cmd push", 32'(sawCmd), 32'd1);
    checkEq("R9 cmd data", cmdSeen, 32'hABCD_1234);
    checkEq("R9 no tx on cmd", 32'(sawTx), 32'd0);
    busWrite(8'hE4, 32'h0000_0177);
    checkEq("R9 tx push", 32'(sawTx), 32'd1);
    checkEq("R9 tx data", 32'(txSeen), 32'h77);
    checkEq("R9 no cmd on tx", 32'(sawCmd), 32'd0);
    busWrite(8'hE8, 32'h5);
    checkEq("R9 no push on other", 32'({sawCmd, sawTx}), 32'd0);
  endtask

  task automatic testPopPeek();
    rxLevel = 5'd2; rxHead = 8'h3C;
    busRead(8'hE8);
    checkEq("R10 pop strobe", 32'(sawPop), 32'd1);
    checkEq("R10 pop data", rd, 32'h3C);
    rxLevel = 5'd0;
    busRead(8'hE8);
    checkEq("R10 no pop empty", 32'(sawPop), 32'd0);
    checkEq("R10 empty data", rd, 32'h0);
    rxLevel = 5'd1; rxHead = 8'h99;
    busRead(8'hEC);
    checkEq("R11 peek no pop", 32'(sawPop), 32'd0);
    checkEq("R11 peek data", rd, 32'h99);
    rxLevel = 5'd0;
    busRead(8'hEC);
    checkEq("R11 peek empty", rd, 32'h0);
  endtask

  task automatic testUnmapped();
    busRead(8'h44); checkEq("R12 unmapped read", rd, 32'h0);
    busRead(8'h41); checkEq("R12 unaligned read", rd, 32'h0);
    busWrite(8'hC0, 32'hFF);
    busRead(8'hC0); checkEq("R12 sync id read-only", rd, 32'hA5);
    busWrite(8'h00, 32'hFFFF_FFFF);
    busRead(8'h00); checkEq("R12 version read-only", rd, 32'h0001_0061);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testVersion();
    testSoftReset();
    testEnable();
    testCauses();
    testIrq();
    testSync();
    testLevels();
    testPush();
    testPopPeek();
    testUnmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule